// File: doc/BRIEF.md
# Vectored Restart Interrupt Encoder

This block gathers eight active-low interrupt request lines and feeds the CPU with one interrupt request. A priority encoder reduces the active lines to a 3-bit level, and the highest-numbered active line wins. When the CPU answers with its acknowledge strobe, the block places a one-byte restart instruction on the data bus. This instruction sends the CPU to a handler at eight times the level. The block therefore needs no separate vector-number register on the CPU side.

Request lines may change at any time, so they pass through a synchronizer before the encoder sees them. The acknowledge strobe is synchronous to the block clock. A small controller has three states:

- `ST_IDLE`: no request.
- `ST_PEND`: a request is raised to the CPU.
- `ST_SERVE`: the acknowledge is in progress and the opcode is on the bus.

The transitions are:

- `ST_IDLE` to `ST_PEND` when any synchronized request is active.
- `ST_PEND` to `ST_IDLE` when all requests go away.
- `ST_IDLE` or `ST_PEND` to `ST_SERVE` when acknowledge is sampled high. This transition captures the level.
- `ST_SERVE` to `ST_PEND` when acknowledge is sampled low and a request remains.
- `ST_SERVE` to `ST_IDLE` when acknowledge is sampled low and no request remains.

Top module: `rst_vector_irq`

## Requirements
- R1: In reset and on the first cycle after reset, `cpu_irq`, `bus_oe` and `bus_data` are all 0.
- R2: A request line held low sets `cpu_irq` high three clock edges after it falls (two synchronizer stages plus the state register). It is still low after two edges.
- R3: When no request line is low and no acknowledge is in progress, `cpu_irq` is 0.
- R4: The encoded level is the index of the highest-numbered request line that is low. Bit 7 has the highest priority.
- R5: The opcode on `bus_data` is binary 11nnn111, where nnn is the encoded level. Its value is 8'hC7 plus eight times the level.
- R6: `bus_oe` goes high on the clock edge after `ack` is first sampled high. It goes low on the edge after `ack` is sampled low.
- R7: The level is captured on the edge that enters `ST_SERVE`. Changes on the request lines during the acknowledge do not alter `bus_data`.
- R8: While `bus_oe` is low, `bus_data` is 8'h00, so the bus stays released.
- R9: `cpu_irq` is low while `bus_oe` is high. It returns high on the edge after `ack` falls if a request is still active.
- R10: An acknowledge with no active request yields the level-0 opcode 8'hC7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | 8 | Interrupt request lines, active low, asynchronous |
| ack | input | 1 | CPU interrupt acknowledge strobe, active high, synchronous |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| bus_data | output | 8 | Restart opcode while driving, 0 otherwise |
| bus_oe | output | 1 | Data bus drive enable, high while the opcode is presented |

## Verification
The assertions check on every cycle that:
- the bus enable tracks the acknowledge strobe with one cycle of delay;
- the opcode always has its fixed 11xxx111 framing and stays constant for the whole acknowledge;
- the bus reads zero whenever it is released;
- the CPU request is never raised during an acknowledge;
- the CPU request is never raised without a synchronized request behind it.

Only the bench scenarios can show:
- that the captured level is the correct priority choice among several active lines;
- the exact three-edge request latency;
- the spurious-acknowledge opcode;
- that the request returns after an acknowledge when a line is still low.

// File: rtl/rvi_pkg.sv
package rvi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_SERVE = 2'd2
    } rvi_state_e;

    localparam logic [7:0] RST_OPC_BASE = 8'hC7;
    localparam int         RST_LVL_LSB  = 3;

endpackage

// File: rtl/rvi_sync.sv
module rvi_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/rvi_prio.sv
module rvi_prio #(
    parameter int N_REQ = 8,
    parameter int LVL_W = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] req,
    output logic             any,
    output logic [LVL_W-1:0] level
);

    always_comb begin
        level = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req[i]) level = LVL_W'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/rvi_fsm.sv
module rvi_fsm
    import rvi_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_any,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              ack,
    output logic              cpu_irq,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_data
);

    rvi_state_e       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack)          state_d = ST_SERVE;
                else if (req_any) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (ack)           state_d = ST_SERVE;
                else if (!req_any) state_d = ST_IDLE;
            end
            ST_SERVE: begin
                if (!ack) state_d = req_any ? ST_PEND : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SERVE && state_d == ST_SERVE)
                lvl_q <= req_any ? req_level : '0;
        end
    end

    always_comb begin
        cpu_irq  = 1'b0;
        bus_oe   = 1'b0;
        bus_data = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PEND:  cpu_irq = 1'b1;
            ST_SERVE: begin
                bus_oe   = 1'b1;
                bus_data = DATA_W'(RST_OPC_BASE) | (DATA_W'(lvl_q) << RST_LVL_LSB);
            end
            default: ;
        endcase
    end

    // R3: a request to the CPU always has a synchronized request behind it
    p_irq_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> $past(req_any));

    // R7: the opcode does not change during one acknowledge
    p_opcode_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_data));

endmodule

// File: rtl/rst_vector_irq.sv
module rst_vector_irq #(
    parameter int N_REQ       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  irq_n,
    input  logic              ack,
    output logic              cpu_irq,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);

    localparam int LVL_W = $clog2(N_REQ);

    logic [N_REQ-1:0] req_sync;
    logic             req_any;
    logic [LVL_W-1:0] req_level;

    rvi_sync #(.WIDTH(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (~irq_n),
        .d_out (req_sync)
    );

    rvi_prio #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_prio (
        .req   (req_sync),
        .any   (req_any),
        .level (req_level)
    );

    rvi_fsm #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_any   (req_any),
        .req_level (req_level),
        .ack       (ack),
        .cpu_irq   (cpu_irq),
        .bus_oe    (bus_oe),
        .bus_data  (bus_data)
    );

    // R6: the bus enable follows the acknowledge one edge later
    p_oe_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> bus_oe);
    p_oe_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !bus_oe);

    // R5: the driven byte keeps its fixed restart framing
    p_opcode_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_data[7:6] == 2'b11 && bus_data[2:0] == 3'b111));

    // R8: a released bus reads zero
    p_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));

    // R9: no CPU request while the opcode is presented
    p_irq_off_serve_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !cpu_irq);

endmodule

// File: tb/rst_vector_irq_test.sv
`timescale 1ns/1ps
module rst_vector_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_n = 8'hFF;
    logic       ack = 1'b0;
    logic       cpu_irq;
    logic [7:0] bus_data;
    logic       bus_oe;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    rst_vector_irq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n    (irq_n),
        .ack      (ack),
        .cpu_irq  (cpu_irq),
        .bus_data (bus_data),
        .bus_oe   (bus_oe)
    );

    // {irq_n, expected level}
    localparam logic [10:0] VEC [10] = '{
        {8'hFE, 3'd0}, {8'hFD, 3'd1}, {8'hFB, 3'd2}, {8'hF5, 3'd3},
        {8'hEF, 3'd4}, {8'hDF, 3'd5}, {8'hBB, 3'd6}, {8'h7F, 3'd7},
        {8'h00, 3'd7}, {8'hC0, 3'd5}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] opc(input logic [2:0] lvl);
        return 8'hC7 | ({5'd0, lvl} << 3);
    endfunction

    initial begin
        #800000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R1 irq in reset", {7'd0, cpu_irq}, 8'h00);
        chk("R1 oe in reset", {7'd0, bus_oe}, 8'h00);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 data after reset", bus_data, 8'h00);
        chk("R1 irq after reset", {7'd0, cpu_irq}, 8'h00);
        cyc(4);
        chk("R3 idle no irq", {7'd0, cpu_irq}, 8'h00);

        for (int v = 0; v < 10; v++) begin
            irq_n = VEC[v][10:3];
            cyc(2);
            chk("R2 irq still low at 2 edges", {7'd0, cpu_irq}, 8'h00);
            cyc(1);
            chk("R2 irq at 3 edges", {7'd0, cpu_irq}, 8'h01);
            ack = 1'b1;
            cyc(1);
            chk("R6 oe rises", {7'd0, bus_oe}, 8'h01);
            chk("R4 R5 opcode", bus_data, opc(VEC[v][2:0]));
            chk("R9 irq low in serve", {7'd0, cpu_irq}, 8'h00);
            cyc(2);
            ack = 1'b0;
            irq_n = 8'hFF;
            cyc(1);
            chk("R6 oe falls", {7'd0, bus_oe}, 8'h00);
            chk("R8 data quiet", bus_data, 8'h00);
            cyc(4);
            chk("R3 irq drops", {7'd0, cpu_irq}, 8'h00);
        end

        // R7: request changes during acknowledge
        irq_n = 8'hFD;
        cyc(4);
        ack = 1'b1;
        cyc(1);
        chk("R7 opcode captured", bus_data, opc(3'd1));
        irq_n = 8'h00;
        cyc(5);
        chk("R7 opcode held", bus_data, opc(3'd1));
        // R9: request remains after acknowledge
        ack = 1'b0;
        cyc(1);
        chk("R9 irq returns", {7'd0, cpu_irq}, 8'h01);
        ack = 1'b1;
        cyc(1);
        chk("R4 new level after change", bus_data, opc(3'd7));
        ack = 1'b0;
        irq_n = 8'hFF;
        cyc(5);

        // R10: spurious acknowledge
        ack = 1'b1;
        cyc(1);
        chk("R10 spurious opcode", bus_data, 8'hC7);
        chk("R10 oe", {7'd0, bus_oe}, 8'h01);
        ack = 1'b0;
        cyc(1);
        chk("R3 idle after spurious", {7'd0, cpu_irq}, 8'h00);

        // R1: reset in the middle of a request
        irq_n = 8'h7F;
        cyc(4);
        ack = 1'b1;
        cyc(1);
        rst_n = 1'b0;
        cyc(1);
        chk("R1 oe cleared by reset", {7'd0, bus_oe}, 8'h00);
        chk("R1 data cleared by reset", bus_data, 8'h00);
        ack = 1'b0;
        irq_n = 8'hFF;
        rst_n = 1'b1;
        cyc(2);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule